// File: doc/BRIEF.md
# Stereo PWM Audio Converter Fed From a Sample Queue

This block turns a stream of 8-bit stereo PCM samples into two one-bit pulse-width outputs, one for each speaker channel. Each 16-bit word from an external show-ahead FIFO holds both channels: the low byte is the left sample and the high byte is the right sample. The FIFO presents its head word whenever it is not empty, and the block acknowledges that word with a one-cycle pop strobe. A prescaler divides the system clock by 9. Each prescaler terminal count advances an 8-bit PWM counter, so one PWM period lasts 2304 clocks. The PWM period is also the sample period. At a 50 MHz clock this gives about 21.7 kHz, close to the nominal 22.05 kHz rate.

A small state machine controls the sample feed. It has three states. FEED_PRIME holds the counters cleared and the outputs low until the first word arrives. FEED_PLAY runs the PWM from fresh samples. FEED_STARVE runs the PWM from held samples after a wrap found the FIFO empty. The named transitions are:
- prime_load (FEED_PRIME to FEED_PLAY, FIFO not empty).
- wrap_load (FEED_PLAY or FEED_STARVE to FEED_PLAY, wrap with data).
- wrap_starve (FEED_PLAY or FEED_STARVE to FEED_STARVE, wrap with the FIFO empty).

New samples are taken only at the state machine's load points. A sample therefore never changes in the middle of a period.

Top module: `pwm_audio_dac`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, pwm_left, pwm_right, fifo_pop and underrun are all 0.
- R2: In the priming state, with fifo_empty high, fifo_pop stays 0 and both outputs stay 0. In the first cycle with fifo_empty low, fifo_pop is 1 and fifo_data is loaded. The PWM counter and the prescaler start from zero in the next cycle.
- R3: The PWM counter advances by one every 9 clocks and wraps from 255 to 0, so one period lasts 2304 clocks. Pops that occur while running are a whole number of periods apart.
- R4: Over each period, an output is 1 exactly while the PWM counter is below that channel's sample. A sample of S therefore gives 9*S high clocks. A sample of 0 is never high, and a sample of 255 is high for 2295 of the 2304 clocks.
- R5: fifo_data[7:0] drives pwm_left and fifo_data[15:8] drives pwm_right.
- R6: While running, fifo_pop is 1 only in the wrap cycle, when the PWM counter is 255 and the prescaler is at its terminal count, and only if fifo_empty is low. The popped word takes effect from the next cycle, at PWM count 0.
- R7: If fifo_empty is high in a wrap cycle, no pop occurs and both previous samples are held. underrun becomes 1 from the next cycle.
- R8: A word that arrives during a starved period is not popped before the next wrap. At that wrap it is popped and loaded, and underrun returns to 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | input | 16 | Head word of the sample FIFO: left byte low, right byte high |
| fifo_empty | input | 1 | High when the FIFO has no word to offer |
| fifo_pop | output | 1 | One-cycle acknowledge of the head word |
| pwm_left | output | 1 | Left channel pulse-width output |
| pwm_right | output | 1 | Right channel pulse-width output |
| underrun | output | 1 | High while the held samples are being replayed because the FIFO was empty at a wrap |

## Verification
Some properties are checked by assertions on every cycle. These are:
- A pop never occurs against an empty FIFO, and never occurs away from PWM count 255 while running.
- The outputs are silent while priming, and a zero sample never drives a high output.
- The PWM counter only ever steps by one.
- Samples stay unchanged on entry to underrun.

Other behaviour shows only in the bench's scenarios, where a behavioural model is compared against the design on every clock. This covers the 2304-clock period and the exact duty of 9*S clocks for the extreme values 0, 1, 128 and 255. It also covers the mapping of bytes to channels, the deferral of a late word to the next wrap, and the clearing of underrun.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;
    typedef enum logic [1:0] {
        FEED_PRIME  = 2'd0,
        FEED_PLAY   = 2'd1,
        FEED_STARVE = 2'd2
    } feed_state_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRESCALE = 9,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] step_cnt,
    output logic         wrap
);
    localparam int             PW       = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0]  PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [W-1:0]   CNT_LAST = {W{1'b1}};

    logic [PW-1:0] pre_cnt;
    logic          pre_term;

    assign pre_term = (pre_cnt == PRE_LAST);
    assign wrap     = run && pre_term && (step_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt  <= '0;
            step_cnt <= '0;
        end else if (pre_term) begin
            pre_cnt  <= '0;
            step_cnt <= step_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_feed_fsm.sv
module pwm_feed_fsm
    import pwm_audio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic wrap,
    output logic fifo_pop,
    output logic load,
    output logic run,
    output logic underrun
);
    feed_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FEED_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FEED_PRIME:  if (!fifo_empty) state_d = FEED_PLAY;
            FEED_PLAY,
            FEED_STARVE: if (wrap) state_d = fifo_empty ? FEED_STARVE : FEED_PLAY;
            default:     state_d = FEED_PRIME;
        endcase
    end

    always_comb begin
        fifo_pop = 1'b0;
        run      = 1'b0;
        underrun = 1'b0;
        unique case (state_q)
            FEED_PRIME:  fifo_pop = !fifo_empty;
            FEED_PLAY: begin
                run      = 1'b1;
                fifo_pop = wrap && !fifo_empty;
            end
            FEED_STARVE: begin
                run      = 1'b1;
                underrun = 1'b1;
                fifo_pop = wrap && !fifo_empty;
            end
            default: ;
        endcase
        load = fifo_pop;
    end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         run,
    input  logic [W-1:0] step_cnt,
    output logic [W-1:0] smp,
    output logic         pwm
);
    always_ff @(posedge clk) begin
        if (!rst_n)    smp <= '0;
        else if (load) smp <= din;
    end

    assign pwm = run && (step_cnt < smp);
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac #(
    parameter int SAMPLE_W = 8,
    parameter int PRESCALE = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*SAMPLE_W-1:0] fifo_data,
    input  logic                  fifo_empty,
    output logic                  fifo_pop,
    output logic                  pwm_left,
    output logic                  pwm_right,
    output logic                  underrun
);
    localparam int NCH = 2;

    logic                run;
    logic                wrap;
    logic                load;
    logic [SAMPLE_W-1:0] step_cnt;
    logic [SAMPLE_W-1:0] chan_smp [NCH];
    logic [NCH-1:0]      chan_pwm;
    logic [SAMPLE_W-1:0] smp_l, smp_r;

    pwm_tick_gen #(.PRESCALE(PRESCALE), .W(SAMPLE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .step_cnt(step_cnt), .wrap(wrap)
    );

    pwm_feed_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .wrap(wrap),
        .fifo_pop(fifo_pop), .load(load), .run(run), .underrun(underrun)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm_slice #(.W(SAMPLE_W)) u_slice (
            .clk(clk), .rst_n(rst_n), .load(load),
            .din(fifo_data[ch*SAMPLE_W +: SAMPLE_W]),
            .run(run), .step_cnt(step_cnt),
            .smp(chan_smp[ch]), .pwm(chan_pwm[ch])
        );
    end

    assign smp_l     = chan_smp[0];
    assign smp_r     = chan_smp[1];
    assign pwm_left  = chan_pwm[0];
    assign pwm_right = chan_pwm[1];
endmodule

// File: rtl/pwm_audio_dac_chk.sv
module pwm_audio_dac_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fifo_empty,
    input logic         fifo_pop,
    input logic         pwm_left,
    input logic         pwm_right,
    input logic         underrun,
    input logic         run,
    input logic [W-1:0] step_cnt,
    input logic [W-1:0] smp_l,
    input logic [W-1:0] smp_r
);
    p_pop_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    p_pop_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && run) |-> (step_cnt == {W{1'b1}}));

    p_prime_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm_left && !pwm_right && !underrun));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (step_cnt != $past(step_cnt)))
            |-> (step_cnt == W'($past(step_cnt) + 1'b1)));

    p_zero_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((smp_l == '0) |-> !pwm_left) and ((smp_r == '0) |-> !pwm_right));

    p_starve_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> ($stable(smp_l) && $stable(smp_r)));
endmodule

bind pwm_audio_dac pwm_audio_dac_chk #(.W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .pwm_left(pwm_left), .pwm_right(pwm_right), .underrun(underrun),
    .run(run), .step_cnt(step_cnt), .smp_l(smp_l), .smp_r(smp_r)
);

// File: tb/test_pwm_audio_dac.sv
`timescale 1ns/1ps
module test_pwm_audio_dac;
    localparam int PER = 9 * 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fifo_data = 16'h0;
    logic        fifo_empty = 1'b1;
    logic        fifo_pop, pwm_left, pwm_right, underrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [15:0] q[$];
    int m_state = 0;   // 0 priming, 1 playing, 2 starved
    int m_pre = 0, m_cnt = 0, m_l = 0, m_r = 0;
    int hi_l = 0, hi_r = 0, last_pop = -1;

    always #10 clk = ~clk;

    pwm_audio_dac i_pwm_audio_dac (
        .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .pwm_left(pwm_left), .pwm_right(pwm_right),
        .underrun(underrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit m_wrap();
        return (m_state != 0) && (m_pre == 8) && (m_cnt == 255);
    endfunction

    function automatic bit m_pop();
        if (!rst_n || fifo_empty) return 0;
        return (m_state == 0) || m_wrap();
    endfunction

    // compare against the model away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk(m_state == 0 ? "R2 pop" : "R6 pop", fifo_pop, m_pop());
            chk("R4 left duty", pwm_left, (m_state != 0) && (m_cnt < m_l));
            chk("R5 right duty", pwm_right, (m_state != 0) && (m_cnt < m_r));
            chk(m_state == 2 ? "R7 underrun" : "R8 underrun", underrun, m_state == 2);
            if (m_state != 0) begin
                hi_l += pwm_left;
                hi_r += pwm_right;
                if (m_wrap()) begin
                    chk("R4 left high clocks per period", hi_l, 9 * m_l);
                    chk("R4 right high clocks per period", hi_r, 9 * m_r);
                    hi_l = 0;
                    hi_r = 0;
                end
                if (fifo_pop) begin
                    if (last_pop >= 0)
                        chk("R3 pop spacing multiple of 2304", (cyc - last_pop) % PER, 0);
                    last_pop = cyc;
                end
            end else if (fifo_pop) begin
                last_pop = cyc;
            end
        end
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // advance the model just after each edge, then present the FIFO head
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_state = 0; m_pre = 0; m_cnt = 0; m_l = 0; m_r = 0;
            hi_l = 0; hi_r = 0;
        end else begin
            bit pop_now, wr;
            pop_now = m_pop();
            wr = m_wrap();
            if (m_state == 0) begin
                if (pop_now) m_state = 1;
            end else begin
                if (m_pre == 8) begin
                    m_pre = 0;
                    m_cnt = (m_cnt + 1) % 256;
                end else begin
                    m_pre++;
                end
                if (wr) m_state = pop_now ? 1 : 2;
            end
            if (pop_now) begin
                m_l = fifo_data[7:0];
                m_r = fifo_data[15:8];
                m_pre = 0;
                if (m_state == 1 && !wr) m_cnt = 0;
                void'(q.pop_front());
            end
        end
        fifo_empty = (q.size() == 0);
        fifo_data  = (q.size() == 0) ? 16'h0 : q[0];
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pwm_left", pwm_left, 0);
        chk("R1 reset pwm_right", pwm_right, 0);
        chk("R1 reset fifo_pop", fifo_pop, 0);
        chk("R1 reset underrun", underrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset outputs", {pwm_left, pwm_right, fifo_pop, underrun}, 0);
        repeat (20) @(negedge clk);
        chk("R2 priming no pop", fifo_pop, 0);
        // left low byte, right high byte
        q.push_back(16'hC0_40);
        q.push_back(16'h00_FF);
        q.push_back(16'hFF_00);
        q.push_back(16'h01_80);
        repeat (4 * PER + PER / 2) @(negedge clk);
        chk("R7 starved after queue drained", underrun, 1);
        // late word arrives mid-period: must wait for the wrap
        q.push_back(16'h20_10);
        @(negedge clk);
        chk("R8 no pop mid-period", fifo_pop, 0);
        repeat (PER) @(negedge clk);
        chk("R8 underrun cleared after reload", underrun, 0);
        chk("R8 late word consumed", q.size(), 0);
        repeat (PER + 100) @(negedge clk);
        chk("R7 starved again", underrun, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule